// File: doc/BRIEF.md
# Crossbar Route Selector with Strap and Register Arbitration

This block produces the control side of a four-input crossbar: for every output port it drives a one-hot input-select vector, an output-enable and a pre-emphasis enable. The analog lanes themselves sit outside. They are driven from these signals. Each output is described by a 3-bit routing code and a pre-emphasis bit. The block chooses where that description comes from.

The hardware straps are already decoded into one routing code per output. They are captured once when reset is released or when power-down is released, and that captured copy drives routing in strap mode. A register write port stands for the serial configuration engine. It stores two control bytes that are packed two outputs per byte. In strap mode those bytes are only stored. A dedicated activation write then hands routing to the registers, and only a power-down cycle or a reset takes that hand-over back. When all straps sit at their mid level at capture time, the block starts in bus mode: the registers drive routing at once, and every output stays off until a byte is written.

Top module: `xbar_route_sel`

## Requirements
- R1: While reset is asserted and on the first sample after it, every bit of out_sel, out_en and out_pe is 0, and both control bytes read as 0x00 in their effect.
- R2: A routing code selects exactly one input: 3'b001 selects input 1, 3'b010 selects input 0, 3'b011 selects input 2 and 3'b100 selects input 3. Output o's select bits are out_sel[o*NUM_IN +: NUM_IN], with bit i meaning input i, and out_en[o] is 1 exactly when an input is selected.
- R3: Code 3'b000 and the reserved codes 3'b101 to 3'b111 leave the output disabled with an all-zero select. In a three-input build, 3'b100 does the same.
- R4: In strap mode, routing follows strap_code as captured on the first clock after reset release (field [3o+2:3o] for output o, with the R2 encoding). Later changes on strap_code have no effect.
- R5: In strap mode, writes to the control bytes do not change any output. A write of any data other than 0xFF to address 0xFF also changes nothing.
- R6: A write of 0xFF to address 0xFF hands routing to the control bytes. After that, strap_code and strap_mid have no effect until power-down or reset.
- R7: If strap_mid is 1 at capture time, the block is in bus mode. Routing then comes from the control bytes straight away, so after reset all outputs stay off until a byte is written.
- R8: While pd_n is 0, out_en and out_pe are all 0 from the next clock and register contents are kept. On release, the straps are captured again, the mode is chosen afresh from them (a hand-over is undone), and the kept register values are used once routing is handed back.
- R9: When pe_all is 1, every output has out_pe set. When pe_all is 0, out_pe follows the per-output register bit in register-driven modes and is 0 in strap mode.
- R10: Address 0x01 holds outputs 0 and 1, and address 0x02 holds outputs 2 and 3. In each byte, bits [2:0] are the code of the even output, bit 3 is its pre-emphasis bit, bits [6:4] are the odd output's code and bit 7 is its pre-emphasis bit. In a three-output build, bits [7:4] of address 0x02 are stored as 0.
- R11: Outputs are registered. A write or activation presented before clock edge k is reflected on the outputs after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down |
| pe_all | input | 1 | Force pre-emphasis on every output |
| strap_mid | input | 1 | All straps at mid level (selects bus mode) |
| strap_code | input | NUM_OUT*3 | Decoded strap routing code per output |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| out_sel | output | NUM_OUT*NUM_IN | One-hot input select per output |
| out_en | output | NUM_OUT | Output enable per output |
| out_pe | output | NUM_OUT | Pre-emphasis enable per output |

## Verification
The bench walks every routing code through the straps. A design that swapped inputs 0 and 1, or that enabled an output on a reserved code, shows the wrong select there. It writes the control bytes before activation, and with the wrong key, to catch a design that lets registers leak into strap mode. It then moves the straps after activation, which exposes a design that keeps watching them. A power-down cycle taken while in register mode must return control to the straps and keep the written bytes; a design that clears the registers, or keeps the hand-over, fails both halves. Random traffic mixes all of these with pe_all and checks every cycle, so an off-by-one in output latency shows up at once.

// File: rtl/xbar_route_pkg.sv
package xbar_route_pkg;

   localparam int CODE_W = 3;

   typedef enum logic [1:0] {
      MODE_STRAP = 2'd0,
      MODE_BUS   = 2'd1,
      MODE_HOST  = 2'd2
   } route_mode_e;

   localparam logic [7:0] ADDR_CTRL_BASE = 8'h01;
   localparam logic [7:0] ADDR_ACT       = 8'hFF;
   localparam logic [7:0] ACT_KEY        = 8'hFF;

   // Routing code that selects a given input index
   function automatic logic [CODE_W-1:0] port_code(input int idx);
      case (idx)
         0:       port_code = 3'b010;
         1:       port_code = 3'b001;
         2:       port_code = 3'b011;
         default: port_code = 3'b100;
      endcase
   endfunction

endpackage

// File: rtl/xbar_code_decode.sv
module xbar_code_decode
   import xbar_route_pkg::*;
#(
   parameter int NUM_IN = 4
) (
   input  logic [CODE_W-1:0] code,
   output logic [NUM_IN-1:0] sel
);

   // One comparator per input; codes with no matching input leave sel zero
   for (genvar i = 0; i < NUM_IN; i++) begin : g_in
      localparam logic [CODE_W-1:0] MATCH = port_code(i);
      assign sel[i] = (code == MATCH);
   end

endmodule

// File: rtl/xbar_ctrl_regs.sv
module xbar_ctrl_regs
   import xbar_route_pkg::*;
#(
   parameter int NUM_OUT = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [7:0]                wr_addr,
   input  logic [7:0]                wr_data,
   output logic [((NUM_OUT+1)/2)*8-1:0] ctrl,
   output logic                      act_hit
);

   localparam int NUM_REGS = (NUM_OUT + 1) / 2;
   localparam bit ODD_OUT  = (NUM_OUT % 2) == 1;

   assign act_hit = wr_en && (wr_addr == ADDR_ACT) && (wr_data == ACT_KEY);

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      localparam logic [7:0] MASK = (ODD_OUT && (r == NUM_REGS - 1)) ? 8'h0F : 8'hFF;
      localparam logic [7:0] ADDR = ADDR_CTRL_BASE + 8'(r);
      logic [7:0] byte_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (wr_en && (wr_addr == ADDR)) begin
            byte_q <= wr_data & MASK;
         end
      end

      assign ctrl[r*8 +: 8] = byte_q;
   end

endmodule

// File: rtl/xbar_route_mode.sv
module xbar_route_mode
   import xbar_route_pkg::*;
#(
   parameter int NUM_OUT = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      pd_n,
   input  logic                      strap_mid,
   input  logic [NUM_OUT*CODE_W-1:0] strap_code,
   input  logic                      act_hit,
   output route_mode_e               mode_q,
   output logic                      sampled_q,
   output logic [NUM_OUT*CODE_W-1:0] snap_q
);

   // Straps are captured on the first powered clock after reset or power-down;
   // activation is honoured only once the capture has happened.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_STRAP;
         sampled_q <= 1'b0;
         snap_q    <= '0;
      end else if (!pd_n) begin
         sampled_q <= 1'b0;
      end else if (!sampled_q) begin
         sampled_q <= 1'b1;
         snap_q    <= strap_code;
         mode_q    <= strap_mid ? MODE_BUS : MODE_STRAP;
      end else if (act_hit) begin
         mode_q    <= MODE_HOST;
      end
   end

endmodule

// File: rtl/xbar_route_sel.sv
module xbar_route_sel
   import xbar_route_pkg::*;
#(
   parameter int NUM_IN  = 4,
   parameter int NUM_OUT = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      pd_n,
   input  logic                      pe_all,
   input  logic                      strap_mid,
   input  logic [NUM_OUT*3-1:0]      strap_code,
   input  logic                      wr_en,
   input  logic [7:0]                wr_addr,
   input  logic [7:0]                wr_data,
   output logic [NUM_OUT*NUM_IN-1:0] out_sel,
   output logic [NUM_OUT-1:0]        out_en,
   output logic [NUM_OUT-1:0]        out_pe
);

   localparam int NUM_REGS = (NUM_OUT + 1) / 2;
   localparam int CTRL_W   = NUM_REGS * 8;
   localparam int FIELD_W  = 4;

   if (NUM_IN < 3 || NUM_IN > 4) begin : g_bad_in
      $error("xbar_route_sel: NUM_IN must be 3 or 4");
   end
   if (NUM_OUT < 1 || NUM_OUT > 4) begin : g_bad_out
      $error("xbar_route_sel: NUM_OUT must be 1 to 4");
   end

   logic [CTRL_W-1:0]         ctrl_bytes;
   logic                      act_hit;
   route_mode_e               mode_q;
   logic                      sampled_q;
   logic [NUM_OUT*CODE_W-1:0] snap_codes;
   logic                      live;

   xbar_ctrl_regs #(.NUM_OUT(NUM_OUT)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .ctrl    (ctrl_bytes),
      .act_hit (act_hit)
   );

   xbar_route_mode #(.NUM_OUT(NUM_OUT)) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .pd_n       (pd_n),
      .strap_mid  (strap_mid),
      .strap_code (strap_code),
      .act_hit    (act_hit),
      .mode_q     (mode_q),
      .sampled_q  (sampled_q),
      .snap_q     (snap_codes)
   );

   assign live = sampled_q && pd_n;

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      // two outputs per byte: even output in the low nibble
      localparam int BASE = o * FIELD_W;

      logic [CODE_W-1:0] reg_code;
      logic              reg_pe;
      logic [CODE_W-1:0] use_code;
      logic              use_pe;
      logic [NUM_IN-1:0] sel_c;
      logic [NUM_IN-1:0] sel_q;
      logic              en_q;
      logic              pe_q;

      assign reg_code = ctrl_bytes[BASE +: CODE_W];
      assign reg_pe   = ctrl_bytes[BASE + CODE_W];

      always_comb begin
         if (mode_q == MODE_STRAP) begin
            use_code = snap_codes[o*CODE_W +: CODE_W];
            use_pe   = 1'b0;
         end else begin
            use_code = reg_code;
            use_pe   = reg_pe;
         end
      end

      xbar_code_decode #(.NUM_IN(NUM_IN)) u_dec (
         .code (use_code),
         .sel  (sel_c)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_q <= '0;
            en_q  <= 1'b0;
            pe_q  <= 1'b0;
         end else if (!live) begin
            sel_q <= '0;
            en_q  <= 1'b0;
            pe_q  <= 1'b0;
         end else begin
            sel_q <= sel_c;
            en_q  <= |sel_c;
            pe_q  <= pe_all | use_pe;
         end
      end

      assign out_sel[o*NUM_IN +: NUM_IN] = sel_q;
      assign out_en[o] = en_q;
      assign out_pe[o] = pe_q;
   end

endmodule

// File: rtl/xbar_route_sel_chk.sv
module xbar_route_sel_chk #(
   parameter int NUM_IN  = 4,
   parameter int NUM_OUT = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      pd_n,
   input logic                      pe_all,
   input logic                      wr_en,
   input logic [7:0]                wr_addr,
   input logic [7:0]                wr_data,
   input logic [NUM_OUT*NUM_IN-1:0] out_sel,
   input logic [NUM_OUT-1:0]        out_en,
   input logic [NUM_OUT-1:0]        out_pe,
   input logic [1:0]                mode,
   input logic                      sampled
);

   localparam logic [1:0] M_STRAP = 2'd0;
   localparam logic [1:0] M_HOST  = 2'd2;

   logic key_write;
   assign key_write = wr_en && (wr_addr == 8'hFF) && (wr_data == 8'hFF);

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_chk
      // R2
      sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(out_sel[o*NUM_IN +: NUM_IN]));
   end

   // R8
   pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_n |=> (out_en == '0) && (out_pe == '0));

   // R9
   pe_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_pe != '0) && $past(pe_all)) |-> (&out_pe));

   // R5
   strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sampled && pd_n && (mode == M_STRAP) && !key_write) |=> (mode == M_STRAP));

   // R6
   host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sampled && pd_n && (mode == M_HOST)) |=> (mode == M_HOST));

endmodule

bind xbar_route_sel xbar_route_sel_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pd_n    (pd_n),
   .pe_all  (pe_all),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .out_sel (out_sel),
   .out_en  (out_en),
   .out_pe  (out_pe),
   .mode    (mode_q),
   .sampled (sampled_q)
);

// File: tb/xbar_route_sel_tb.sv
module xbar_route_sel_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pd_n = 1'b1;
   logic        pe_all = 1'b0;
   logic        strap_mid = 1'b0;
   logic [11:0] strap_code = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [15:0] out_sel;
   logic [3:0]  out_en;
   logic [3:0]  out_pe;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   // reference state
   logic [15:0] m_regs;
   logic [11:0] m_snap;
   int          m_mode;   // 0 strap, 1 bus, 2 host
   bit          m_samp;

   always #5 clk = ~clk;

   xbar_route_sel u_dut (
      .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .pe_all(pe_all),
      .strap_mid(strap_mid), .strap_code(strap_code),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .out_sel(out_sel), .out_en(out_en), .out_pe(out_pe)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles == 50000) begin
         fails++;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   function automatic logic [3:0] dec(input logic [2:0] c);
      case (c)
         3'b001:  dec = 4'b0010;
         3'b010:  dec = 4'b0001;
         3'b011:  dec = 4'b0100;
         3'b100:  dec = 4'b1000;
         default: dec = 4'b0000;
      endcase
   endfunction

   task automatic compare(input string tag, input logic [15:0] es,
                          input logic [3:0] ee, input logic [3:0] ep);
      checks++;
      if (out_sel !== es || out_en !== ee || out_pe !== ep) begin
         fails++;
         $display("FAIL %s: sel=%h en=%h pe=%h expected sel=%h en=%h pe=%h",
                  tag, out_sel, out_en, out_pe, es, ee, ep);
      end
   endtask

   task automatic tick(input string tag);
      logic [15:0] ns = '0;
      logic [3:0]  ne = '0;
      logic [3:0]  np = '0;
      if (m_samp && pd_n) begin
         for (int o = 0; o < 4; o++) begin
            logic [2:0] c;
            logic       p;
            logic [3:0] d;
            c = (m_mode == 0) ? m_snap[o*3 +: 3] : m_regs[o*4 +: 3];
            p = (m_mode == 0) ? 1'b0 : m_regs[o*4 + 3];
            d = dec(c);
            ns[o*4 +: 4] = d;
            ne[o] = |d;
            np[o] = p | pe_all;
         end
      end
      if (wr_en && wr_addr == 8'h01) m_regs[7:0]  = wr_data;
      if (wr_en && wr_addr == 8'h02) m_regs[15:8] = wr_data;
      if (!pd_n) m_samp = 1'b0;
      else if (!m_samp) begin
         m_samp = 1'b1;
         m_snap = strap_code;
         m_mode = strap_mid ? 1 : 0;
      end else if (wr_en && wr_addr == 8'hFF && wr_data == 8'hFF) m_mode = 2;
      @(posedge clk);
      @(negedge clk);
      compare(tag, ns, ne, np);
   endtask

   task automatic write(input logic [7:0] a, input logic [7:0] d, input string tag);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick(tag);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wr_en = 1'b0;
      m_regs = '0; m_snap = '0; m_mode = 0; m_samp = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      // R1: everything off during reset
      compare("R1", '0, '0, '0);
      rst_n = 1'b1;
   endtask

   task automatic power_cycle(input string tag);
      pd_n = 1'b0;
      tick(tag);
      tick(tag);
      pd_n = 1'b1;
   endtask

   initial begin
      void'($urandom(32'd1234));
      // strap: out0=in1, out1=in0, out2=in2, out3=in3
      strap_code = {3'b100, 3'b011, 3'b010, 3'b001};
      do_reset();
      tick("R1");
      repeat (2) tick("R4");

      // R4: strap changes after capture are ignored
      strap_code = {3'b001, 3'b001, 3'b001, 3'b001};
      repeat (3) tick("R4");

      // R2 / R3: every code through a fresh strap capture
      for (int c = 0; c < 8; c++) begin
         strap_code = {4{c[2:0]}};
         power_cycle((c >= 1 && c <= 4) ? "R2" : "R3");
         repeat (3) tick((c >= 1 && c <= 4) ? "R2" : "R3");
      end

      strap_code = {3'b100, 3'b011, 3'b010, 3'b001};
      power_cycle("R4");
      repeat (2) tick("R4");

      // R5: register writes and a wrong key stay invisible in strap mode
      write(8'h01, 8'h23, "R5");
      write(8'h02, 8'h41, "R5");
      repeat (2) tick("R5");
      write(8'hFF, 8'h7F, "R5");
      write(8'hFE, 8'hFF, "R5");
      repeat (2) tick("R5");

      // R11: activation shows one edge after the mode change
      write(8'hFF, 8'hFF, "R11");
      tick("R11");
      tick("R11");

      // R10: field positions
      write(8'h01, 8'h9A, "R10");
      write(8'h02, 8'h3C, "R10");
      repeat (2) tick("R10");

      // R6: straps ignored after hand-over
      strap_code = {3'b010, 3'b010, 3'b010, 3'b010};
      strap_mid = 1'b1;
      repeat (3) tick("R6");
      strap_mid = 1'b0;

      // R9: forced pre-emphasis
      pe_all = 1'b1;
      repeat (3) tick("R9");
      pe_all = 1'b0;
      tick("R9");

      // R8: power-down keeps registers, undoes hand-over
      pd_n = 1'b0;
      tick("R8");
      write(8'h01, 8'h31, "R8");
      tick("R8");
      pd_n = 1'b1;
      repeat (3) tick("R8");
      write(8'hFF, 8'hFF, "R8");
      repeat (2) tick("R8");

      // R7: bus mode from mid-level straps
      strap_mid = 1'b1;
      do_reset();
      repeat (3) tick("R7");
      write(8'h01, 8'hB4, "R7");
      repeat (2) tick("R7");
      write(8'h02, 8'h12, "R7");
      repeat (2) tick("R7");

      // random mix
      strap_mid = 1'b0;
      for (int n = 0; n < 400; n++) begin
         int r;
         r = $urandom % 16;
         pd_n   = (r != 8);
         pe_all = ($urandom % 4) == 0;
         if (r == 9)  strap_code = 12'($urandom);
         if (r == 10) strap_mid  = $urandom % 2;
         if (r < 3)       write(8'h01, 8'($urandom), "R11");
         else if (r < 6)  write(8'h02, 8'($urandom), "R11");
         else if (r == 6) write(8'hFF, 8'hFF, "R6");
         else if (r == 7) write(8'hFF, 8'($urandom), "R5");
         else             tick("R2");
      end
      pd_n = 1'b1;
      tick("R2");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule